// File: doc/BRIEF.md
# Unified TLB Address Translator

This block turns a 32-bit virtual data address into a physical address, or into a fault code, in a single registered step. A request carries the address, the access direction and the privilege level, and it is sampled together with the MMU control word, the page-table-entry-high word (which holds the current address-space ID) and a flat array of translation entries. The result appears on the clock edge after the request.

The block first checks two fixed untranslated windows. Addresses in those windows map straight through with their top three bits cleared, and user-mode code may reach only a small slice of them. For all other addresses, when translation is enabled, every entry is compared in parallel. Each entry has its own page size (1 KB, 4 KB, 64 KB or 1 MB), can be tagged with an address-space ID or marked shared, and has access-protection and dirty fields. Duplicate matches, misses, protection violations and first writes to clean pages each return their own fault code. The block also returns the next value of the entry-replacement counter, which the owner of the control word writes back.

Entry loading and exception dispatch belong to neighbouring blocks.

Top module: `utlb_xlate`

## Requirements
- R1: An address in 0x8000_0000..0xBFFF_FFFF or in 0xE000_0000..0xFFFF_FFFF, accessed in privileged mode, returns code 0 and a physical address equal to the virtual address with bits 31:29 cleared. The entries are not consulted.
- R2: In user mode, an address in those windows is allowed only from 0xE000_0000 to 0xE400_0000 inclusive, and it then maps as in R1. Any other address in the windows returns 0x040 for a read and 0x060 for a write.
- R3: When control-word bit 0 (translation enable) is 0, every address outside the windows of R1 returns code 0 and the address with bits 31:29 cleared.
- R4: Entry i occupies array bits [56*i +: 56]. From the MSB down: valid(55), shared(54), dirty(53), prot(52:51), size(50:49), asid(48:41), vpn(40:19), ppn(18:0). Size 0/1/2/3 selects a 1 KB/4 KB/64 KB/1 MB page. The page start is {vpn,10'b0} with the in-page bits cleared. On a hit, the physical address is {ppn,10'b0} with the in-page bits cleared, ORed with the in-page bits of the virtual address.
- R5: The entry ASID is compared with word bits 7:0 of the PTEH input only when control-word bit 8 (single-virtual mode) is 0 and the access is in user mode. A shared entry matches any ASID.
- R6: If two or more valid entries match, the code is 0x140 for either direction. This check takes priority over protection.
- R7: If no valid entry matches, the code is 0x040 for a read and 0x060 for a write.
- R8: Protection: in user mode, prot 0 and 1 deny all access and prot 2 denies writes. In privileged mode, prot 0 and 2 deny writes. A denied read returns 0x0A0 and a denied write returns 0x0C0.
- R9: A permitted write that hits an entry with dirty=0 returns 0x080.
- R10: For a request that reaches the entry search, the counter output is (c+1), with c taken from control bits 15:10. It is 0 instead when c+1 equals the boundary in bits 23:18 or when c+1 is at least N_ENTRIES-1. For every other request, the counter output equals c.
- R11: Each request produces exactly one response, on the clock edge after it is sampled, and back-to-back requests are accepted. A fault sets rsp_fault and returns paddr 0.
- R12: During reset and on cycles with no response, rsp_valid, rsp_fault and rsp_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| mmu_ctl | input | 32 | Control word: enable bit 0, single-virtual bit 8, counter 15:10, boundary 23:18 |
| pteh_word | input | 32 | Current ASID in bits 7:0 |
| tlb_array | input | 56*N_ENTRIES | Packed translation entries |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 12 | Fault code, 0 when there is no fault |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_repl | output | 6 | Next replacement-counter value |

## Verification
The in-line properties check rules that hold on every cycle. A successful response never carries bits above 28. With translation off in privileged mode, the address always passes straight through. Fault codes always agree with the access direction. The counter stays below the last entry index after a search, and an idle output is quiet. The scoreboard scenarios are the only way to show the rest. That covers the page-size alignment with stray low VPN and PPN bits, ASID filtering against shared entries and the single-virtual override, the ordering of duplicate-hit, protection and clean-page checks, the edges of the user window, and the counter wrap on the boundary and on the last entry.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

   localparam int VADDR_W = 32;
   localparam int VPN_W   = 22;
   localparam int PPN_W   = 19;
   localparam int ASID_W  = 8;
   localparam int CNT_W   = 6;
   localparam int CODE_W  = 12;

   // control word bit positions decoded by this block
   localparam int CTL_AT_BIT  = 0;
   localparam int CTL_SV_BIT  = 8;
   localparam int CTL_CNT_LSB = 10;
   localparam int CTL_BND_LSB = 18;

   typedef struct packed {
      logic              valid;
      logic              shared;
      logic              dirty;
      logic [1:0]        prot;
      logic [1:0]        szc;
      logic [ASID_W-1:0] asid;
      logic [VPN_W-1:0]  vpn;
      logic [PPN_W-1:0]  ppn;
   } tlb_entry_t;

   localparam int ENTRY_W = $bits(tlb_entry_t);

   localparam logic [CODE_W-1:0] FC_NONE     = 12'h000;
   localparam logic [CODE_W-1:0] FC_RD_MISS  = 12'h040;
   localparam logic [CODE_W-1:0] FC_WR_MISS  = 12'h060;
   localparam logic [CODE_W-1:0] FC_CLEAN_WR = 12'h080;
   localparam logic [CODE_W-1:0] FC_RD_PROT  = 12'h0A0;
   localparam logic [CODE_W-1:0] FC_WR_PROT  = 12'h0C0;
   localparam logic [CODE_W-1:0] FC_MULTI    = 12'h140;

   // in-page offset mask for a size code
   function automatic logic [VADDR_W-1:0] page_mask(input logic [1:0] szc);
      case (szc)
         2'd0:    page_mask = 32'h0000_03FF;
         2'd1:    page_mask = 32'h0000_0FFF;
         2'd2:    page_mask = 32'h0000_FFFF;
         default: page_mask = 32'h000F_FFFF;
      endcase
   endfunction

   // access denied by the protection field
   function automatic logic prot_denies(input logic [1:0] prot,
                                        input logic priv,
                                        input logic wr);
      if (priv) prot_denies = wr && !prot[0];
      else      prot_denies = !prot[1] || (wr && !prot[0]);
   endfunction

endpackage

// File: rtl/tlbx_region.sv
module tlbx_region
   import tlbx_pkg::*;
#(
   parameter logic [VADDR_W-1:0] USER_LO = 32'hE000_0000,
   parameter logic [VADDR_W-1:0] USER_HI = 32'hE400_0000
) (
   input  logic [VADDR_W-1:0] vaddr,
   input  logic               priv,
   input  logic               at_en,
   output logic               direct,
   output logic               deny,
   output logic               search
);

   if (USER_LO > USER_HI) begin : g_bad_window
      $error("tlbx_region: user window bounds reversed");
   end

   logic in_window;
   logic user_ok;

   always_comb begin
      in_window = (vaddr[31:30] == 2'b10) || (vaddr[31:29] == 3'b111);
      user_ok   = (vaddr >= USER_LO) && (vaddr <= USER_HI);
      deny      = in_window && !priv && !user_ok;
      direct    = (in_window && !deny) || (!in_window && !at_en);
      search    = !in_window && at_en;
   end

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 8
) (
   input  logic [VADDR_W-1:0]           vaddr,
   input  logic [N_ENTRIES*ENTRY_W-1:0] tlb_array,
   input  logic                         use_asid,
   input  logic [ASID_W-1:0]            cur_asid,
   output logic [N_ENTRIES-1:0]         hit
);

   if (N_ENTRIES < 2 || N_ENTRIES > 64) begin : g_bad_depth
      $error("tlbx_match: N_ENTRIES must be 2..64");
   end

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      tlb_entry_t         ent;
      logic [VADDR_W-1:0] msk;
      logic [VADDR_W-1:0] base;
      logic               asid_ok;
      logic               unused_fields;

      assign ent           = tlb_entry_t'(tlb_array[i*ENTRY_W +: ENTRY_W]);
      assign msk           = page_mask(ent.szc);
      assign base          = {ent.vpn, 10'b0};
      assign asid_ok       = !use_asid || ent.shared || (ent.asid == cur_asid);
      assign hit[i]        = ent.valid && asid_ok && ((vaddr & ~msk) == (base & ~msk));
      assign unused_fields = ^{ent.ppn, ent.dirty, ent.prot};
   end

endmodule

// File: rtl/tlbx_select.sv
module tlbx_select
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 8
) (
   input  logic [N_ENTRIES-1:0]         hit,
   input  logic [N_ENTRIES*ENTRY_W-1:0] tlb_array,
   output tlb_entry_t                   sel,
   output logic                         any_hit,
   output logic                         multi_hit
);

   always_comb begin
      sel       = '0;
      any_hit   = 1'b0;
      multi_hit = 1'b0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (hit[i]) begin
            if (any_hit) multi_hit = 1'b1;
            any_hit = 1'b1;
            sel     = sel | tlb_entry_t'(tlb_array[i*ENTRY_W +: ENTRY_W]);
         end
      end
   end

endmodule

// File: rtl/tlbx_repl.sv
module tlbx_repl
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 8
) (
   input  logic [CNT_W-1:0] cur,
   input  logic [CNT_W-1:0] bnd,
   output logic [CNT_W-1:0] nxt
);

   localparam logic [CNT_W:0] LAST = (CNT_W+1)'(N_ENTRIES - 1);

   logic [CNT_W:0] inc;

   always_comb begin
      inc = {1'b0, cur} + 1'b1;
      if ((inc == {1'b0, bnd}) || (inc >= LAST)) nxt = '0;
      else                                       nxt = inc[CNT_W-1:0];
   end

endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [31:0]                  req_vaddr,
   input  logic                         req_write,
   input  logic                         req_priv,
   input  logic [31:0]                  mmu_ctl,
   input  logic [31:0]                  pteh_word,
   input  logic [N_ENTRIES*ENTRY_W-1:0] tlb_array,
   output logic                         rsp_valid,
   output logic                         rsp_fault,
   output logic [CODE_W-1:0]            rsp_code,
   output logic [31:0]                  rsp_paddr,
   output logic [CNT_W-1:0]             rsp_repl
);

   if (N_ENTRIES < 2 || N_ENTRIES > (1 << CNT_W)) begin : g_bad_depth
      $error("utlb_xlate: N_ENTRIES out of counter range");
   end

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_ENTRIES - 1);

   logic             at_en, sv_mode, use_asid;
   logic [CNT_W-1:0] cnt_cur, cnt_bnd, cnt_adv;
   logic             direct, deny, search;
   logic [N_ENTRIES-1:0] hit;
   tlb_entry_t       sel;
   logic             any_hit, multi_hit;
   logic [31:0]      msk;

   assign at_en    = mmu_ctl[CTL_AT_BIT];
   assign sv_mode  = mmu_ctl[CTL_SV_BIT];
   assign cnt_cur  = mmu_ctl[CTL_CNT_LSB +: CNT_W];
   assign cnt_bnd  = mmu_ctl[CTL_BND_LSB +: CNT_W];
   assign use_asid = !sv_mode && !req_priv;

   tlbx_region u_region (
      .vaddr  (req_vaddr),
      .priv   (req_priv),
      .at_en  (at_en),
      .direct (direct),
      .deny   (deny),
      .search (search)
   );

   tlbx_match #(.N_ENTRIES(N_ENTRIES)) u_match (
      .vaddr     (req_vaddr),
      .tlb_array (tlb_array),
      .use_asid  (use_asid),
      .cur_asid  (pteh_word[ASID_W-1:0]),
      .hit       (hit)
   );

   tlbx_select #(.N_ENTRIES(N_ENTRIES)) u_select (
      .hit       (hit),
      .tlb_array (tlb_array),
      .sel       (sel),
      .any_hit   (any_hit),
      .multi_hit (multi_hit)
   );

   tlbx_repl #(.N_ENTRIES(N_ENTRIES)) u_repl (
      .cur (cnt_cur),
      .bnd (cnt_bnd),
      .nxt (cnt_adv)
   );

   logic unused_bits;
   assign unused_bits = ^{mmu_ctl[31:24], mmu_ctl[17:16], mmu_ctl[9], mmu_ctl[7:1],
                          pteh_word[31:ASID_W], sel.valid, sel.shared, sel.asid, sel.vpn};

   logic [CODE_W-1:0] code_d;
   logic [31:0]       pa_d;
   logic [CNT_W-1:0]  repl_d;

   always_comb begin
      msk    = page_mask(sel.szc);
      code_d = FC_NONE;
      pa_d   = '0;
      repl_d = search ? cnt_adv : cnt_cur;
      if (deny)                                     code_d = req_write ? FC_WR_MISS : FC_RD_MISS;
      else if (direct)                              pa_d   = req_vaddr & 32'h1FFF_FFFF;
      else if (multi_hit)                           code_d = FC_MULTI;
      else if (!any_hit)                            code_d = req_write ? FC_WR_MISS : FC_RD_MISS;
      else if (prot_denies(sel.prot, req_priv, req_write))
                                                    code_d = req_write ? FC_WR_PROT : FC_RD_PROT;
      else if (req_write && !sel.dirty)             code_d = FC_CLEAN_WR;
      else pa_d = ({3'b000, sel.ppn, 10'b0} & ~msk) | (req_vaddr & msk);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_code  <= FC_NONE;
         rsp_paddr <= '0;
         rsp_repl  <= '0;
      end else if (req_valid) begin
         rsp_valid <= 1'b1;
         rsp_fault <= (code_d != FC_NONE);
         rsp_code  <= code_d;
         rsp_paddr <= pa_d;
         rsp_repl  <= repl_d;
      end else begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_code  <= FC_NONE;
         rsp_paddr <= '0;
         rsp_repl  <= '0;
      end
   end

   // R1 / R4: no successful response reaches above bit 28
   a_r1_phys_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[31:29] == 3'b000);

   // R3: translation off in privileged mode always passes through
   a_r3_at_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_priv && !mmu_ctl[CTL_AT_BIT])
      |-> !rsp_fault && rsp_paddr == ($past(req_vaddr) & 32'h1FFF_FFFF));

   // R7: write faults only carry write-side codes
   a_r7_write_codes: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault && $past(req_write)
      |-> rsp_code == FC_WR_MISS || rsp_code == FC_CLEAN_WR ||
          rsp_code == FC_WR_PROT || rsp_code == FC_MULTI);

   // R8: read faults only carry read-side codes
   a_r8_read_codes: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault && !$past(req_write)
      |-> rsp_code == FC_RD_MISS || rsp_code == FC_RD_PROT || rsp_code == FC_MULTI);

   // R10: after a search the counter never lands on the last entry
   a_r10_cnt_below_last: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(search) |-> rsp_repl < LAST_IDX);

   // R12: idle output is quiet
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_fault && rsp_code == FC_NONE);

endmodule

// File: tb/utlb_xlate_test.sv
`timescale 1ns/1ps
module utlb_xlate_test;
   import tlbx_pkg::*;

   localparam int N = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [31:0]       req_vaddr = '0;
   logic              req_write = 1'b0;
   logic              req_priv = 1'b0;
   logic [31:0]       mmu_ctl = '0;
   logic [31:0]       pteh_word = 32'hABCD_EF05;
   logic [N*ENTRY_W-1:0] tlb_array = '0;
   logic              rsp_valid, rsp_fault;
   logic [CODE_W-1:0] rsp_code;
   logic [31:0]       rsp_paddr;
   logic [CNT_W-1:0]  rsp_repl;

   utlb_xlate #(.N_ENTRIES(N)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_priv(req_priv), .mmu_ctl(mmu_ctl),
      .pteh_word(pteh_word), .tlb_array(tlb_array), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
      .rsp_repl(rsp_repl)
   );

   typedef struct {
      logic [11:0] code;
      logic [31:0] pa;
      logic [5:0]  cnt;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   failures = 0;
   int   cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic tlb_entry_t mk(input logic v, input logic sh, input logic d,
                                     input logic [1:0] pr, input logic [1:0] sz,
                                     input logic [7:0] asid, input logic [21:0] vpn,
                                     input logic [18:0] ppn);
      tlb_entry_t e;
      e.valid = v; e.shared = sh; e.dirty = d; e.prot = pr; e.szc = sz;
      e.asid = asid; e.vpn = vpn; e.ppn = ppn;
      return e;
   endfunction

   // stray bits in fields the block must ignore
   function automatic logic [31:0] mk_ctl(input logic at, input logic sv,
                                          input logic [5:0] cnt, input logic [5:0] bnd);
      return 32'hA500_0000 | 32'h0003_02FE | {31'b0, at} | ({31'b0, sv} << 8) |
             ({26'b0, cnt} << 10) | ({26'b0, bnd} << 18);
   endfunction

   task automatic send(input logic [31:0] va, input logic wr, input logic pv,
                       input logic [31:0] ctl, input logic [11:0] code,
                       input logic [31:0] pa, input logic [5:0] cnt, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_priv = pv; mmu_ctl = ctl;
      e.code = code; e.pa = pa; e.cnt = cnt; e.cyc = cyc; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor: pop and compare as responses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
               failures++;
               $display("FAIL R11 unexpected response: code=%h expected none", rsp_code);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (rsp_code !== e.code || rsp_fault !== (e.code != 12'h0) ||
                   rsp_paddr !== e.pa || rsp_repl !== e.cnt || cyc != e.cyc + 1) begin
                  failures++;
                  $display("FAIL %s: code=%h fault=%b paddr=%h cnt=%0d cyc=%0d expected code=%h paddr=%h cnt=%0d cyc=%0d",
                           e.tag, rsp_code, rsp_fault, rsp_paddr, rsp_repl, cyc,
                           e.code, e.pa, e.cnt, e.cyc + 1);
               end
            end
         end else if (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            failures++;
            $display("FAIL R11 missing response for %s: rsp_valid=0 expected 1", e.tag);
         end else if (rsp_fault !== 1'b0 || rsp_code !== 12'h0) begin
            checks++;
            failures++;
            $display("FAIL R12 idle output: fault=%b code=%h expected 0 0", rsp_fault, rsp_code);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tlb_entry_t ents [N];
      logic [31:0] C0, CA, CS, C1, C2, C3;
      ents[0] = mk(1, 0, 1, 2'd3, 2'd1, 8'h05, 22'h4,    19'h48C);  // 4K  0x1000 -> 0x123000
      ents[1] = mk(1, 0, 1, 2'd2, 2'd0, 8'h05, 22'h11,   19'h20);   // 1K  0x4400 -> 0x8000
      ents[2] = mk(1, 0, 0, 2'd3, 2'd2, 8'h05, 22'h47,   19'h1403); // 64K 0x10000 -> 0x500000, clean
      ents[3] = mk(1, 1, 1, 2'd1, 2'd3, 8'h77, 22'h1000, 19'h4000); // 1M  shared
      ents[4] = mk(1, 0, 1, 2'd3, 2'd1, 8'h09, 22'h18,   19'h30);   // 4K  other ASID
      ents[5] = mk(1, 0, 1, 2'd3, 2'd1, 8'h05, 22'h20,   19'h40);   // 4K  0x8000
      ents[6] = mk(1, 0, 1, 2'd3, 2'd0, 8'h05, 22'h21,   19'h50);   // 1K  overlaps entry 5
      ents[7] = mk(0, 0, 1, 2'd3, 2'd1, 8'h05, 22'h28,   19'h60);   // invalid
      for (int i = 0; i < N; i++) tlb_array[i*ENTRY_W +: ENTRY_W] = ents[i];
      C0 = mk_ctl(1, 0, 6'd3, 6'd0);
      CA = mk_ctl(0, 0, 6'd3, 6'd0);
      CS = mk_ctl(1, 1, 6'd3, 6'd0);
      C1 = mk_ctl(1, 0, 6'd4, 6'd5);
      C2 = mk_ctl(1, 0, 6'd6, 6'd0);
      C3 = mk_ctl(1, 0, 6'd2, 6'd0);

      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_code !== 12'h0) begin
         failures++;
         $display("FAIL R12 reset: valid=%b fault=%b code=%h expected 0 0 0",
                  rsp_valid, rsp_fault, rsp_code);
      end
      rst_n = 1'b1;
      idle(2);

      // R1 untranslated windows, privileged
      send(32'h8123_4567, 0, 1, C0, 12'h000, 32'h0123_4567, 6'd3, "R1 low window");
      send(32'hA000_0010, 0, 1, C0, 12'h000, 32'h0000_0010, 6'd3, "R1 upper half");
      send(32'hF000_0000, 1, 1, C0, 12'h000, 32'h1000_0000, 6'd3, "R1 top window write");
      // R2 user window edges
      send(32'hE000_0000, 0, 0, C0, 12'h000, 32'h0000_0000, 6'd3, "R2 window low edge");
      send(32'hE400_0000, 1, 0, C0, 12'h000, 32'h0400_0000, 6'd3, "R2 window high edge");
      send(32'hE400_0004, 0, 0, C0, 12'h040, 32'h0, 6'd3, "R2 above window read");
      send(32'h9000_0000, 1, 0, C0, 12'h060, 32'h0, 6'd3, "R2 user write low window");
      idle(3);
      // R3 translation disabled
      send(32'h7234_5678, 1, 1, CA, 12'h000, 32'h1234_5678, 6'd3, "R3 at off");
      send(32'h0000_1000, 0, 1, CA, 12'h000, 32'h0000_1000, 6'd3, "R3 at off ignores entries");
      send(32'h0000_4400, 1, 0, CA, 12'h000, 32'h0000_4400, 6'd3, "R3 at off user write");
      // R4 page sizes and alignment
      send(32'h0000_1ABC, 0, 1, C0, 12'h000, 32'h0012_3ABC, 6'd4, "R4 4K page");
      send(32'h0000_47FF, 0, 1, C0, 12'h000, 32'h0000_83FF, 6'd4, "R4 1K page top");
      send(32'h0000_4800, 0, 1, C0, 12'h040, 32'h0, 6'd4, "R4 1K page end");
      send(32'h0001_F00C, 0, 1, C0, 12'h000, 32'h0050_F00C, 6'd4, "R4 64K aligned");
      send(32'h004A_BCDE, 0, 1, C0, 12'h000, 32'h010A_BCDE, 6'd4, "R4 1M page");
      // R5 ASID handling
      send(32'h0000_6010, 0, 0, C0, 12'h040, 32'h0, 6'd4, "R5 asid mismatch user");
      send(32'h0000_6010, 0, 0, CS, 12'h000, 32'h0000_C010, 6'd4, "R5 single virtual");
      send(32'h0000_6010, 0, 1, C0, 12'h000, 32'h0000_C010, 6'd4, "R5 privileged skips asid");
      send(32'h0000_1004, 0, 0, C0, 12'h000, 32'h0012_3004, 6'd4, "R5 asid match user");
      send(32'h0040_0000, 0, 0, C0, 12'h0A0, 32'h0, 6'd4, "R5 shared entry matches");
      idle(1);
      // R6 duplicate match
      send(32'h0000_8500, 0, 1, C0, 12'h140, 32'h0, 6'd4, "R6 multi read");
      send(32'h0000_8500, 1, 0, C0, 12'h140, 32'h0, 6'd4, "R6 multi user write");
      send(32'h0000_8000, 0, 1, C0, 12'h000, 32'h0001_0000, 6'd4, "R6 single of pair");
      // R7 misses on invalid entry
      send(32'h0000_A000, 0, 1, C0, 12'h040, 32'h0, 6'd4, "R7 read miss");
      send(32'h0000_A004, 1, 0, C0, 12'h060, 32'h0, 6'd4, "R7 write miss");
      // R8 protection
      send(32'h0000_4400, 0, 0, C0, 12'h000, 32'h0000_8000, 6'd4, "R8 user read prot2");
      send(32'h0000_4400, 1, 0, C0, 12'h0C0, 32'h0, 6'd4, "R8 user write prot2");
      send(32'h0000_4400, 1, 1, C0, 12'h0C0, 32'h0, 6'd4, "R8 priv write prot2");
      send(32'h0040_0010, 1, 0, C0, 12'h0C0, 32'h0, 6'd4, "R8 user write prot1");
      send(32'h0040_0010, 1, 1, C0, 12'h000, 32'h0100_0010, 6'd4, "R8 priv write prot1");
      // R9 first write to clean page
      send(32'h0001_0004, 1, 1, C0, 12'h080, 32'h0, 6'd4, "R9 clean priv write");
      send(32'h0001_0004, 1, 0, C0, 12'h080, 32'h0, 6'd4, "R9 clean user write");
      send(32'h0000_1000, 1, 1, C0, 12'h000, 32'h0012_3000, 6'd4, "R9 dirty write ok");
      idle(2);
      // R10 replacement counter
      send(32'h0000_1000, 0, 1, C1, 12'h000, 32'h0012_3000, 6'd0, "R10 wrap on boundary");
      send(32'h0000_A000, 0, 1, C2, 12'h040, 32'h0, 6'd0, "R10 wrap at last entry");
      send(32'h0000_1000, 0, 1, C3, 12'h000, 32'h0012_3000, 6'd3, "R10 plain increment");
      send(32'h8000_0000, 0, 1, C2, 12'h000, 32'h0000_0000, 6'd6, "R10 held without search");
      idle(4);

      checks++;
      if (q.size() != 0) begin
         failures++;
         $display("FAIL R11 leftover: pending=%0d expected 0", q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule